// File: doc/BRIEF.md
# Disk Drive Link Sequencer

This block stands in for a floppy-style disk drive on the drive side of a serial link to a disk host adaptor. It reports media presence and write permission to the host and keeps the motor-good line active. When the host asks for a scan, it waits a fixed preparation time counted in bit periods, then asserts an active-low ready line. While ready is active it steps a media bit pointer once per bit period. It either drives stored media bits back to the host or hands the host's write stream to the storage side.

The transfer ends when the host releases its scan line or pulls its stop line low. The stop line wins over every other input. The transfer also ends when the pointer passes the last bit of the media, and an end-of-media flag then stays up until the host drops its request. The storage array and the bit encoding sit outside. This block only supplies a pointer, a per-bit advance strobe, a record strobe with its data bit, and it takes one media bit back.

Top module: `drive_link_seq`

## Requirements
- R1: `mediaSetN_o` is the inverse of `mediaPresent_i`, registered, so it follows one clock edge later (low means media present).
- R2: `writableN_o` is low only when media is present and `writeProtect_i` is low. When media arrives unprotected, it falls on the same clock edge as `mediaSetN_o`.
- R3: `motorOk_o` is high at all times, including during reset.
- R4: A request is `scanN_i` low with `stopMotorN_i` high. `readyN_o` falls exactly `PREP_BITS*CLKS_PER_BIT` clock edges after the first edge that sees the request, and never sooner.
- R5: When `scanN_i` goes high, `readyN_o` is high after the next clock edge.
- R6: When `stopMotorN_i` is low, it ends any transfer even while `scanN_i` stays low. `readyN_o` is high after the next edge, and no advance or record strobe is issued while stop is held.
- R7: During a transfer with `writeN_i` high, `readData_o` equals `mediaBit_i`, and `bitStrobe_o` pulses for one clock once every `CLKS_PER_BIT` clocks, with `recordEn_o` low. Outside this direction `readData_o` is 0.
- R8: During a transfer with `writeN_i` low, `recordEn_o` pulses once per bit period with `recordBit_o` equal to `writeData_i`, and `readData_o` is 0.
- R9: `mediaAddr_o` is 0 after any edge at which the request is absent. It increases by one per bit period while ready is active.
- R10: After `MEDIA_BITS` bit periods of transfer, `readyN_o` goes high and `endOfMedia_o` goes high with `mediaAddr_o` at `MEDIA_BITS-1`. Both hold until the request is removed, and then `endOfMedia_o` clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mediaPresent_i | input | 1 | Local media-present status |
| writeProtect_i | input | 1 | Local write-protect status |
| scanN_i | input | 1 | Host scan request, active low |
| stopMotorN_i | input | 1 | Host stop command, active low |
| writeN_i | input | 1 | Host direction, low selects recording |
| writeData_i | input | 1 | Host serial write stream |
| mediaBit_i | input | 1 | Bit read from storage at the current pointer |
| mediaSetN_o | output | 1 | Media present to host, active low |
| writableN_o | output | 1 | Media writable to host, active low |
| motorOk_o | output | 1 | Motor on / battery good, always high |
| readyN_o | output | 1 | Head ready and advancing, active low |
| readData_o | output | 1 | Serial read stream to host |
| bitStrobe_o | output | 1 | One-clock advance strobe per bit period |
| recordEn_o | output | 1 | Record strobe toward storage |
| recordBit_o | output | 1 | Bit to record |
| mediaAddr_o | output | ADDR_W | Media bit pointer |
| endOfMedia_o | output | 1 | Pointer ran off the end of the media |

## Verification
The hardest case to reach is the stop line overriding an active transfer while scan stays low and the host is in record direction. The stimulus first brings the block to ready in record direction, then drops stop on its own and counts record strobes across whole bit periods. After that it releases stop while scan is still low, which must start a fresh preparation delay. The end-of-media case is reached with small bench parameters, so a full pass over the media takes a few dozen clocks.

// File: rtl/drive_link_pkg.sv
package drive_link_pkg;
  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_PREP = 2'd1,
    S_XFER = 2'd2,
    S_DONE = 2'd3
  } seqState_t;

  typedef struct packed {
    logic clearPtr;
    logic advance;
    logic driveRead;
    logic record;
  } strobes_t;
endpackage

// File: rtl/bit_tick_gen.sv
module bit_tick_gen #(
  parameter int CLKS_PER_BIT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic tick
);
  localparam int CNT_W = (CLKS_PER_BIT > 1) ? $clog2(CLKS_PER_BIT) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CLKS_PER_BIT - 1);

  logic [CNT_W-1:0] phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            phase <= '0;
    else if (restart)      phase <= '0;
    else if (phase == LAST) phase <= '0;
    else                   phase <= phase + 1'b1;
  end

  assign tick = !restart && (phase == LAST);
endmodule

// File: rtl/drive_link_ctrl.sv
module drive_link_ctrl
  import drive_link_pkg::*;
#(
  parameter int CLKS_PER_BIT = 4,
  parameter int PREP_BITS    = 14354
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     scanN,
  input  logic     stopN,
  input  logic     writeN,
  input  logic     tick,
  input  logic     lastBit,
  output logic     tickRestart,
  output strobes_t strobes,
  output logic     readyN,
  output logic     endOfMedia
);
  localparam int PREP_W = $clog2(PREP_BITS + 1);
  localparam logic [PREP_W-1:0] PREP_LAST = PREP_W'(PREP_BITS - 1);
  localparam logic [31:0] MIN_CLKS = 32'(PREP_BITS * CLKS_PER_BIT);

  seqState_t state, nextState;
  logic [PREP_W-1:0] prepCnt;
  logic req, inXfer;

  assign req    = !scanN && stopN;
  assign inXfer = (state == S_XFER);

  always_comb begin
    nextState = state;
    if (!req) nextState = S_IDLE;
    else begin
      unique case (state)
        S_IDLE: nextState = S_PREP;
        S_PREP: if (tick && prepCnt == PREP_LAST) nextState = S_XFER;
        S_XFER: if (tick && lastBit) nextState = S_DONE;
        S_DONE: nextState = S_DONE;
        default: nextState = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      prepCnt <= '0;
    end else begin
      state <= nextState;
      if (state != S_PREP)  prepCnt <= '0;
      else if (tick)        prepCnt <= prepCnt + 1'b1;
    end
  end

  assign tickRestart       = (state == S_IDLE);
  assign strobes.clearPtr  = !req;
  assign strobes.advance   = inXfer && req && tick;
  assign strobes.driveRead = inXfer && req && writeN;
  assign strobes.record    = inXfer && req && !writeN && tick;
  assign readyN            = !inXfer;
  assign endOfMedia        = (state == S_DONE);

  // Checker counter: clocks the request has been continuously present.
  logic [31:0] sinceReq;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                sinceReq <= '0;
    else if (!req)             sinceReq <= '0;
    else if (sinceReq != '1)   sinceReq <= sinceReq + 1'b1;
  end

  assert_ready_min_delay_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(readyN) |-> (sinceReq >= MIN_CLKS));
  assert_scan_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    scanN |=> readyN);
  assert_stop_priority_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !stopN |=> (readyN && !strobes.record && !strobes.advance));
  assert_eom_not_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
    endOfMedia |-> readyN);
endmodule

// File: rtl/drive_link_path.sv
module drive_link_path
  import drive_link_pkg::*;
#(
  parameter int MEDIA_BITS = 524288,
  localparam int ADDR_W = (MEDIA_BITS > 1) ? $clog2(MEDIA_BITS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mediaPresent,
  input  logic              writeProtect,
  input  strobes_t          strobes,
  input  logic              mediaBit,
  input  logic              writeData,
  output logic              mediaSetN,
  output logic              writableN,
  output logic              readData,
  output logic              bitStrobe,
  output logic              recordEn,
  output logic              recordBit,
  output logic [ADDR_W-1:0] addr,
  output logic              lastBit
);
  localparam logic [ADDR_W-1:0] ADDR_LAST = ADDR_W'(MEDIA_BITS - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mediaSetN <= 1'b1;
      writableN <= 1'b1;
    end else begin
      mediaSetN <= !mediaPresent;
      writableN <= !(mediaPresent && !writeProtect);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             addr <= '0;
    else if (strobes.clearPtr)              addr <= '0;
    else if (strobes.advance && !lastBit)   addr <= addr + 1'b1;
  end

  assign lastBit   = (addr == ADDR_LAST);
  assign readData  = strobes.driveRead && mediaBit;
  assign bitStrobe = strobes.advance;
  assign recordEn  = strobes.record;
  assign recordBit = strobes.record && writeData;

  assert_writable_needs_media_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !writableN |-> !mediaSetN);
  assert_ptr_cleared_R9: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.clearPtr |=> (addr == '0));
  assert_read_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !strobes.driveRead |-> !readData);
endmodule

// File: rtl/drive_link_seq.sv
module drive_link_seq
  import drive_link_pkg::*;
#(
  parameter int CLKS_PER_BIT = 519,
  parameter int PREP_BITS    = 14354,
  parameter int MEDIA_BITS   = 524288,
  localparam int ADDR_W = (MEDIA_BITS > 1) ? $clog2(MEDIA_BITS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mediaPresent_i,
  input  logic              writeProtect_i,
  input  logic              scanN_i,
  input  logic              stopMotorN_i,
  input  logic              writeN_i,
  input  logic              writeData_i,
  input  logic              mediaBit_i,
  output logic              mediaSetN_o,
  output logic              writableN_o,
  output logic              motorOk_o,
  output logic              readyN_o,
  output logic              readData_o,
  output logic              bitStrobe_o,
  output logic              recordEn_o,
  output logic              recordBit_o,
  output logic [ADDR_W-1:0] mediaAddr_o,
  output logic              endOfMedia_o
);
  strobes_t strobes;
  logic tick, tickRestart, lastBit;

  assign motorOk_o = 1'b1;

  bit_tick_gen #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_tick (
    .clk(clk), .rst_n(rst_n), .restart(tickRestart), .tick(tick)
  );

  drive_link_ctrl #(.CLKS_PER_BIT(CLKS_PER_BIT), .PREP_BITS(PREP_BITS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .scanN(scanN_i), .stopN(stopMotorN_i),
    .writeN(writeN_i), .tick(tick), .lastBit(lastBit),
    .tickRestart(tickRestart), .strobes(strobes),
    .readyN(readyN_o), .endOfMedia(endOfMedia_o)
  );

  drive_link_path #(.MEDIA_BITS(MEDIA_BITS)) u_path (
    .clk(clk), .rst_n(rst_n), .mediaPresent(mediaPresent_i),
    .writeProtect(writeProtect_i), .strobes(strobes),
    .mediaBit(mediaBit_i), .writeData(writeData_i),
    .mediaSetN(mediaSetN_o), .writableN(writableN_o),
    .readData(readData_o), .bitStrobe(bitStrobe_o),
    .recordEn(recordEn_o), .recordBit(recordBit_o),
    .addr(mediaAddr_o), .lastBit(lastBit)
  );
endmodule

// File: tb/sim_drive_link_seq.sv
module sim_drive_link_seq;
  localparam int CPB   = 4;
  localparam int PREP  = 10;
  localparam int MEDIA = 16;
  localparam int NPREP = PREP * CPB;
  localparam int AW    = $clog2(MEDIA);

  // {present, protect, expected mediaSetN, expected writableN}
  localparam logic [3:0] VEC [6] = '{4'b0011, 4'b1101, 4'b1000,
                                     4'b0011, 4'b1000, 4'b0111};

  logic clk = 0, rst_n = 0;
  logic present = 0, protect = 0, scanN = 1, stopN = 1, writeN = 1;
  logic wData = 0, mBit = 0;
  logic setN, wrN, motorOk, readyN, rData, bStrobe, recEn, recBit, eom;
  logic [AW-1:0] addr;
  int nChecks = 0, nFails = 0;

  always #5 clk = ~clk;

  drive_link_seq #(.CLKS_PER_BIT(CPB), .PREP_BITS(PREP), .MEDIA_BITS(MEDIA)) u0 (
    .clk(clk), .rst_n(rst_n), .mediaPresent_i(present), .writeProtect_i(protect),
    .scanN_i(scanN), .stopMotorN_i(stopN), .writeN_i(writeN),
    .writeData_i(wData), .mediaBit_i(mBit),
    .mediaSetN_o(setN), .writableN_o(wrN), .motorOk_o(motorOk),
    .readyN_o(readyN), .readData_o(rData), .bitStrobe_o(bStrobe),
    .recordEn_o(recEn), .recordBit_o(recBit), .mediaAddr_o(addr),
    .endOfMedia_o(eom)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic drive_at_negedge();
    @(negedge clk);
  endtask

  task automatic count_strobes(input int n, output int nb, output int nr, output int badBit);
    nb = 0; nr = 0; badBit = 0;
    for (int i = 0; i < n; i++) begin
      step(1);
      if (bStrobe) nb++;
      if (recEn) begin
        nr++;
        if (recBit != wData) badBit++;
      end
    end
  endtask

  initial begin
    #2000000;
    nFails++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    int nb, nr, bad;
    step(2);
    chk("R3 motorOk in reset", motorOk, 1);
    chk("R4 readyN in reset", readyN, 1);
    chk("R1 mediaSetN in reset", setN, 1);
    drive_at_negedge();
    rst_n = 1;
    step(1);

    // Table: media status
    for (int v = 0; v < 6; v++) begin
      drive_at_negedge();
      present = VEC[v][3];
      protect = VEC[v][2];
      step(1);
      chk("R1 mediaSetN", setN, VEC[v][1]);
      chk("R2 writableN", wrN, VEC[v][0]);
    end

    // Read transfer
    drive_at_negedge();
    present = 1; protect = 0; writeN = 1; mBit = 1;
    scanN = 0; stopN = 1;
    step(NPREP);
    chk("R4 readyN before delay", readyN, 1);
    chk("R9 addr during prep", addr, 0);
    step(1);
    chk("R4 readyN after delay", readyN, 0);
    chk("R3 motorOk", motorOk, 1);
    count_strobes(3 * CPB, nb, nr, bad);
    chk("R7 read strobes", nb, 3);
    chk("R7 no record in read", nr, 0);
    chk("R9 addr after 3 bits", addr, 3);
    chk("R7 readData follows media 1", rData, 1);
    drive_at_negedge(); mBit = 0; #1;
    chk("R7 readData follows media 0", rData, 0);

    // Write direction
    drive_at_negedge();
    writeN = 0; wData = 1; mBit = 1;
    count_strobes(2 * CPB, nb, nr, bad);
    chk("R8 record strobes", nr, 2);
    chk("R8 record bit", bad, 0);
    chk("R8 readData quiet", rData, 0);
    chk("R9 addr after 5 bits", addr, 5);

    // Scan release
    drive_at_negedge();
    scanN = 1; writeN = 1;
    step(1);
    chk("R5 readyN on scan release", readyN, 1);
    chk("R9 addr cleared", addr, 0);
    chk("R7 readData outside transfer", rData, 0);

    // Stop priority in record direction
    drive_at_negedge();
    scanN = 0; writeN = 0;
    step(NPREP + 1);
    chk("R6 ready before stop", readyN, 0);
    drive_at_negedge();
    stopN = 0;
    step(1);
    chk("R6 readyN on stop", readyN, 1);
    count_strobes(2 * CPB, nb, nr, bad);
    chk("R6 no record while stopped", nr, 0);
    chk("R6 no advance while stopped", nb, 0);
    chk("R9 addr cleared by stop", addr, 0);

    // Release stop with scan still low: fresh delay, then run to end of media
    drive_at_negedge();
    stopN = 1; writeN = 1;
    step(NPREP);
    chk("R4 readyN before restarted delay", readyN, 1);
    step(1);
    chk("R4 readyN after restarted delay", readyN, 0);
    step(MEDIA * CPB - 1);
    chk("R10 ready on last bit", readyN, 0);
    chk("R10 no eom yet", eom, 0);
    step(1);
    chk("R10 readyN at end", readyN, 1);
    chk("R10 eom set", eom, 1);
    chk("R10 addr at last", addr, MEDIA - 1);
    step(5);
    chk("R10 eom held", eom, 1);
    chk("R10 readyN held", readyN, 1);
    drive_at_negedge();
    scanN = 1;
    step(1);
    chk("R10 eom cleared", eom, 0);
    chk("R1 mediaSetN held", setN, 0);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule